// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock for an I2C master. A programmable prescaler divides the kernel clock into a time unit. Separate high and low counts then set how many of those units each clock phase lasts. The block does not run as a free divider. Each phase is timed from the moment its edge is actually seen on the bus, through a two-flop synchronizer. Because of this, a slave that stretches the clock lengthens the low phase, and another master that pulls the line low early shortens the high phase. Neither case needs any special handling.

The output is an open-drain control: a 1 pulls SCL low, and a 0 releases it so the pull-up takes it high. Two one-cycle strobes are provided for the neighbouring shift logic. One marks the last cycle of each low phase, which is the data setup point. The other marks each falling edge seen on the line.

The prescaler and both counts are captured while the block is disabled and are frozen while it is enabled. Dropping the enable acts as a soft reset.

Top module: `i2c_scl_gen`

## Requirements
- R1: While reset is asserted, `scl_pull_low`, `low_end_strobe` and `fall_strobe` are all 0.
- R2: When enabled with `run` low, the block keeps SCL released (`scl_pull_low` = 0).
- R3: With the line following the output, SCL is pulled low for (low_count+1)·(prescale+1)+3 kernel cycles. The +3 is the two synchronizer flops plus one state update.
- R4: With the line following the output, SCL stays released for (high_count+1)·(prescale+1)+3 kernel cycles before it is pulled low again.
- R5: If SCL is held low externally after the block releases it, the block keeps it released and starts no new low drive. The high count starts only when a rising edge is seen, and the next pull-low comes (high_count+1)·(prescale+1)+3 cycles after the line is freed.
- R6: If another device pulls SCL low during the high phase, the block starts pulling low 3 cycles later. It then holds the line low for (low_count+1)·(prescale+1) cycles from that point.
- R7: Clearing `enable` releases SCL in the same cycle, and SCL stays released while disabled, even with `run` high. On the next enable, the block starts a fresh low phase of full length.
- R8: Changes to `prescale`, `high_count` and `low_count` made while enabled have no effect. They take effect after a disable/enable cycle.
- R9: A `run` request starts with a pull-low one cycle after it is seen. When `run` drops, the block finishes the current high phase and then leaves SCL released.
- R10: `low_end_strobe` pulses for exactly one cycle per low phase, in the last cycle before SCL is released.
- R11: `fall_strobe` pulses for exactly one cycle for each falling edge seen on the synchronized line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; clearing it is a soft reset |
| prescale | input | 4 | Time unit = prescale+1 kernel cycles |
| high_count | input | 8 | High phase = high_count+1 units |
| low_count | input | 8 | Low phase = low_count+1 units |
| run | input | 1 | Request to generate clock cycles |
| scl_in | input | 1 | Raw sampled SCL line level |
| scl_pull_low | output | 1 | 1 drives SCL low, 0 releases it |
| low_end_strobe | output | 1 | One-cycle pulse in the last cycle of a low phase |
| fall_strobe | output | 1 | One-cycle pulse on each seen falling edge |

## Verification
A wrong phase state or a corrupt counter shows up as an SCL low or high time that differs from the formula. This is visible at `scl_pull_low` by the end of the affected phase, which is at most (255+1)·(15+1)+3 cycles. A state that misreads the synchronized line appears as early release during stretching, or as a missing pull-low within 3 cycles of an external low during the high phase. A setup strobe that is missing, duplicated or misplaced is visible in the same low phase, on the cycle just before release.

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int PW   = 4,
  parameter int CW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [PW-1:0] prescale,
  input  logic [CW-1:0] high_count,
  input  logic [CW-1:0] low_count,
  input  logic          run,
  input  logic          scl_in,
  output logic          scl_pull_low,
  output logic          low_end_strobe,
  output logic          fall_strobe
);

  typedef enum logic [2:0] {S_IDLE, S_PULL, S_LOW, S_REL, S_HIGH} state_t;

  state_t state, state_n;
  logic [PW-1:0] cfg_pre, pc;
  logic [CW-1:0] cfg_high, cfg_low, uc;
  logic [SYNC-1:0] sync;
  logic scl_s, scl_d;

  assign scl_s = sync[SYNC-1];

  wire [CW-1:0] lim  = (state == S_HIGH) ? cfg_high : cfg_low;
  wire          tick = (pc == cfg_pre);
  wire          done = tick && (uc == lim);

  assign scl_pull_low   = enable && (state == S_PULL || state == S_LOW);
  assign low_end_strobe = enable && (state == S_LOW) && done;
  assign fall_strobe    = enable && scl_d && !scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= '1;
      scl_d <= 1'b1;
    end else begin
      sync  <= {sync[SYNC-2:0], scl_in};
      scl_d <= scl_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_pre  <= '0;
      cfg_high <= '0;
      cfg_low  <= '0;
    end else if (!enable) begin
      cfg_pre  <= prescale;
      cfg_high <= high_count;
      cfg_low  <= low_count;
    end
  end

  always_comb begin
    state_n = state;
    if (!enable) state_n = S_IDLE;
    else begin
      case (state)
        S_IDLE: if (run) state_n = S_PULL;
        S_PULL: if (!scl_s) state_n = S_LOW;
        S_LOW:  if (done) state_n = S_REL;
        S_REL:  if (scl_s) state_n = S_HIGH;
        S_HIGH: begin
          if (!scl_s)    state_n = S_LOW;
          else if (done) state_n = run ? S_PULL : S_IDLE;
        end
        default: state_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc    <= '0;
      uc    <= '0;
    end else begin
      state <= state_n;
      if (state_n != state || !(state == S_LOW || state == S_HIGH)) begin
        pc <= '0;
        uc <= '0;
      end else if (tick) begin
        pc <= '0;
        uc <= uc + 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !scl_pull_low && !low_end_strobe && !fall_strobe);

  a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !run && state == S_IDLE |=> !scl_pull_low);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_LOW |-> uc <= cfg_low && pc <= cfg_pre);

  a_r5_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    enable && state == S_REL && !scl_s |=> state == S_REL || state == S_IDLE);

  a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> state == S_IDLE && pc == '0 && uc == '0);

  a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    enable && $past(enable) |-> $stable({cfg_pre, cfg_high, cfg_low}));

  a_r10_release_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    low_end_strobe |=> !scl_pull_low);

  a_r11_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall_strobe |=> !fall_strobe);

endmodule

// File: tb/tb_i2c_scl_gen.sv
module tb_i2c_scl_gen;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, enable, run, hold;
  logic [3:0] prescale;
  logic [7:0] high_count, low_count;
  logic       scl_pull_low, low_end_strobe, fall_strobe;
  wire        scl_in = !scl_pull_low && !hold;

  i2c_scl_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
    .high_count(high_count), .low_count(low_count), .run(run), .scl_in(scl_in),
    .scl_pull_low(scl_pull_low), .low_end_strobe(low_end_strobe), .fall_strobe(fall_strobe)
  );

  int checks = 0, fails = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pull(input logic v, output int n, output int n_le, output int le_at, output int n_fs);
    n = 0; n_le = 0; le_at = -1; n_fs = 0;
    while (scl_pull_low !== v && n < 20000) begin
      @(negedge clk);
      n++;
      if (scl_pull_low !== v) begin
        if (low_end_strobe) begin n_le++; le_at = n; end
        if (fall_strobe) n_fs++;
      end
    end
  endtask

  localparam logic [19:0] VEC [0:3] = '{20'h00000, 20'h10302, 20'h30507, 20'h20901};

  initial begin
    int n, lo, hi, le, la, fs, lo_e, hi_e;
    bit ok;
    rst_n = 0; enable = 0; run = 0; hold = 0;
    prescale = 0; high_count = 0; low_count = 0;
    repeat (3) @(negedge clk);
    chk(!scl_pull_low && !low_end_strobe && !fall_strobe, "R1 reset outputs", scl_pull_low, 0);
    rst_n = 1;
    @(negedge clk);
    enable = 1;
    ok = 1;
    repeat (10) begin @(negedge clk); if (scl_pull_low) ok = 0; end
    chk(ok, "R2 idle released", !ok, 0);

    for (int i = 0; i < 4; i++) begin
      enable = 0;
      {prescale, high_count, low_count} = VEC[i];
      lo_e = (int'(low_count) + 1) * (int'(prescale) + 1) + 3;
      hi_e = (int'(high_count) + 1) * (int'(prescale) + 1) + 3;
      repeat (2) @(negedge clk);
      enable = 1;
      @(negedge clk);
      run = 1;
      wait_pull(1, n, le, la, fs);
      chk(n == 1, "R9 start latency", n, 1);
      for (int k = 0; k < 2; k++) begin
        wait_pull(0, lo, le, la, fs);
        chk(lo == lo_e, "R3 low time", lo, lo_e);
        chk(le == 1 && la == lo - 1, "R10 setup strobe", la, lo - 1);
        chk(fs == 1, "R11 fall strobe count", fs, 1);
        if (k == 0) begin
          wait_pull(1, hi, le, la, fs);
          chk(hi == hi_e, "R4 high time", hi, hi_e);
        end
      end
      run = 0;
      ok = 1;
      repeat (hi_e + 20) begin @(negedge clk); if (scl_pull_low) ok = 0; end
      chk(ok, "R9 stop after high", !ok, 0);
    end

    enable = 0;
    prescale = 1; low_count = 4; high_count = 6;
    repeat (2) @(negedge clk);
    enable = 1; run = 1;
    wait_pull(1, n, le, la, fs);
    prescale = 3; low_count = 9; high_count = 1;
    wait_pull(0, lo, le, la, fs);
    chk(lo == 13, "R8 locked low", lo, 13);
    wait_pull(1, hi, le, la, fs);
    chk(hi == 17, "R8 locked high", hi, 17);
    run = 0;
    repeat (40) @(negedge clk);
    enable = 0;
    repeat (2) @(negedge clk);
    enable = 1; run = 1;
    wait_pull(1, n, le, la, fs);
    wait_pull(0, lo, le, la, fs);
    chk(lo == 43, "R8 new low after re-enable", lo, 43);

    hold = 1;
    ok = 1;
    repeat (30) begin @(negedge clk); if (scl_pull_low || low_end_strobe) ok = 0; end
    chk(ok, "R5 stretch keeps released", !ok, 0);
    hold = 0;
    wait_pull(1, hi, le, la, fs);
    chk(hi == 11, "R5 high after stretch", hi, 11);

    wait_pull(0, lo, le, la, fs);
    repeat (4) @(negedge clk);
    hold = 1;
    repeat (2) @(negedge clk);
    chk(!scl_pull_low, "R6 not yet pulling", scl_pull_low, 0);
    @(negedge clk);
    chk(scl_pull_low, "R6 joins external low", scl_pull_low, 1);
    hold = 0;
    wait_pull(0, lo, le, la, fs);
    chk(lo == 40, "R6 low counted from external edge", lo, 40);

    wait_pull(1, n, le, la, fs);
    repeat (5) @(negedge clk);
    enable = 0;
    #1;
    chk(!scl_pull_low && !low_end_strobe, "R7 immediate release", scl_pull_low, 0);
    ok = 1;
    repeat (10) begin @(negedge clk); if (scl_pull_low) ok = 0; end
    chk(ok, "R7 stays released while disabled", !ok, 0);
    enable = 1;
    wait_pull(1, n, le, la, fs);
    chk(n == 1, "R7 restart latency", n, 1);
    wait_pull(0, lo, le, la, fs);
    chk(lo == 43, "R7 fresh full low", lo, 43);
    run = 0;
    repeat (30) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule